// File: doc/BRIEF.md
# Masked Column Projection Stream

The block trims columns out of a table that streams past it one 32-bit word per beat, in row order. Software-side control hands it a column-select mask (one bit per column, a set bit keeps the column), the number of columns per row and the number of rows, then pulses `start`. From then on every input word is either passed straight to the output or silently consumed, depending on the mask bit of the column it belongs to. No row is ever stored; the block only tracks which column and which row the next input word belongs to.

The output stream carries a flag on the last kept word of every row and another on the last kept word of the whole table, so a downstream consumer can frame the narrower rows. The width of the projected row, which is the count of kept columns, is published as soon as a job is accepted. A job whose mask keeps no column is refused with an error flag and completes at once without touching the stream.

Top module: `colproj_stream`

## Requirements
- R1: A `start` pulse while idle latches `cfg_mask`, `cfg_cols` and `cfg_rows`; later changes to those inputs, and further `start` pulses while `busy` is high, have no effect on the running job.
- R2: The column position begins at 0 and wraps to 0 after `cfg_cols` accepted input beats, advancing the row count; after `cfg_cols` x `cfg_rows` accepted beats, `done` is high for exactly one cycle in the next cycle and `busy` is low from then on.
- R3: On a kept column (mask bit 1), `out_valid` equals `in_valid`, `out_data` equals `in_data` in the same cycle, and `in_ready` equals `out_ready`.
- R4: On a dropped column (mask bit 0), `out_valid` is low and `in_ready` is high whatever `out_ready` is.
- R5: Mask bits at positions equal to or above `cfg_cols` are ignored; a `cfg_cols` value above 32 is treated as 32.
- R6: `out_row_last` is high with the kept word of the highest-numbered kept column of each row; `out_tbl_last` is high only with that word in the final row.
- R7: `out_width` equals the number of kept columns of the latest accepted job, updated at its `start` and held until the next accepted `start`.
- R8: If no column is kept, the cycle after `start` shows `err` high, a one-cycle `done` and `busy` low, and no beat is accepted; `err` stays high until the next accepted `start` with a non-empty mask, which clears it.
- R9: A job with `cfg_rows` of 0 and a non-empty mask completes with a one-cycle `done` in the next cycle, `err` low and no beat accepted.
- R10: After reset, `busy`, `done`, `err`, `in_ready` and `out_valid` are low and `out_width` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Job launch pulse, honoured only while idle |
| cfg_mask | input | 32 | Column-select mask, bit i keeps column i |
| cfg_cols | input | 6 | Columns per input row, 1 to 32 |
| cfg_rows | input | 16 | Rows in the table |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 32 | Input column word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output column word |
| out_row_last | output | 1 | Last kept word of a row |
| out_tbl_last | output | 1 | Last kept word of the table |
| out_width | output | 6 | Kept columns per output row |
| busy | output | 1 | Job running |
| done | output | 1 | One-cycle pulse when a job ends |
| err | output | 1 | Last launch had an empty effective mask |

## Verification
The assertions assume that upstream holds `in_valid` and `in_data` steady while a word waits during a job; the output-stability property rests on it, since the block has no storage of its own. The stimulus keeps to this by re-presenting the same word whenever `in_ready` was low, even under randomised input gaps, and by driving `in_valid` high only while a job is running or while the block is idle and refuses it. Configuration inputs are scrambled right after each launch and a stray `start` is pulsed mid-job, so the latched copy is what the checks see.

// File: rtl/colproj_pkg.sv
// Shared definitions for the column projection stream.
// Assumes nothing beyond being compiled before the modules that use it.
package colproj_pkg;

    // Run phase of the projection job.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/colproj_cfg.sv
// Configuration latch for one projection job.
// Clamps the column count, clears mask bits beyond it, and captures the
// effective mask, the counter limits, the kept-column count and the index
// of the highest kept column on a launch.
// Assumes MAX_COLS >= 2.
module colproj_cfg #(
    parameter int MAX_COLS = 32,
    parameter int ROW_W    = 16,
    localparam int COL_W   = $clog2(MAX_COLS),
    localparam int CNT_W   = $clog2(MAX_COLS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [MAX_COLS-1:0] cfg_mask,
    input  logic [CNT_W-1:0]    cfg_cols,
    input  logic [ROW_W-1:0]    cfg_rows,
    output logic                bad_cfg,
    output logic                no_rows,
    output logic [MAX_COLS-1:0] keep_mask_q,
    output logic [COL_W-1:0]    cols_m1_q,
    output logic [ROW_W-1:0]    rows_m1_q,
    output logic [CNT_W-1:0]    width_q,
    output logic [COL_W-1:0]    last_col_q
);

    logic [CNT_W-1:0]    cols_cl;
    logic [MAX_COLS-1:0] eff_mask;
    logic [CNT_W-1:0]    kept_cnt;
    logic [COL_W-1:0]    last_idx;

    // Clamp the column count to the widest supported row.
    always_comb begin
        cols_cl = (cfg_cols > CNT_W'(MAX_COLS)) ? CNT_W'(MAX_COLS) : cfg_cols;
    end

    // Keep only mask bits that name an existing column.
    for (genvar g = 0; g < MAX_COLS; g++) begin : g_eff
        assign eff_mask[g] = cfg_mask[g] & (CNT_W'(g) < cols_cl);
    end

    // Count kept columns and find the highest kept index.
    always_comb begin
        kept_cnt = '0;
        last_idx = '0;
        for (int i = 0; i < MAX_COLS; i++) begin
            kept_cnt = kept_cnt + CNT_W'(eff_mask[i]);
            if (eff_mask[i]) begin
                last_idx = COL_W'(i);
            end
        end
    end

    // Flag launches that keep nothing or carry no rows.
    always_comb begin
        bad_cfg = (eff_mask == '0);
        no_rows = (cfg_rows == '0);
    end

    // Capture the job configuration on an accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_mask_q <= '0;
            cols_m1_q   <= '0;
            rows_m1_q   <= '0;
            width_q     <= '0;
            last_col_q  <= '0;
        end else if (launch) begin
            keep_mask_q <= eff_mask;
            cols_m1_q   <= COL_W'(cols_cl - CNT_W'(1));
            rows_m1_q   <= cfg_rows - ROW_W'(1);
            width_q     <= kept_cnt;
            last_col_q  <= last_idx;
        end
    end

endmodule

// File: rtl/colproj_walker.sv
// Position tracker for the projection job.
// Walks the column index from 0 to the configured width minus 1, counts
// rows, and ends the job after the final column of the final row.
// Raises the error flag for launches with an empty effective mask.
// Assumes launch is only asserted while idle.
module colproj_walker #(
    parameter int MAX_COLS = 32,
    parameter int ROW_W    = 16,
    localparam int COL_W   = $clog2(MAX_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             bad_cfg,
    input  logic             no_rows,
    input  logic             beat,
    input  logic [COL_W-1:0] cols_m1,
    input  logic [ROW_W-1:0] rows_m1,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q
);
    import colproj_pkg::*;

    phase_e phase_q;

    // Busy whenever a job is in its run phase.
    assign busy = (phase_q == PH_RUN);

    // Advance phase, position counters, done pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (launch) begin
                        col_q <= '0;
                        row_q <= '0;
                        if (bad_cfg) begin
                            err  <= 1'b1;
                            done <= 1'b1;
                        end else if (no_rows) begin
                            err  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            err     <= 1'b0;
                            phase_q <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (beat) begin
                        if (col_q == cols_m1) begin
                            col_q <= '0;
                            if (row_q == rows_m1) begin
                                phase_q <= PH_IDLE;
                                done    <= 1'b1;
                            end else begin
                                row_q <= row_q + ROW_W'(1);
                            end
                        end else begin
                            col_q <= col_q + COL_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/colproj_gate.sv
// Beat gate for the projection stream.
// Passes a kept word straight through with its handshake, swallows a
// dropped word without waiting on the output, and marks row and table ends.
// Assumes the mask, limits and last index are stable while busy.
module colproj_gate #(
    parameter int MAX_COLS = 32,
    parameter int ROW_W    = 16,
    localparam int COL_W   = $clog2(MAX_COLS)
) (
    input  logic                busy,
    input  logic [MAX_COLS-1:0] keep_mask,
    input  logic [COL_W-1:0]    col,
    input  logic [ROW_W-1:0]    row,
    input  logic [COL_W-1:0]    last_col,
    input  logic [ROW_W-1:0]    rows_m1,
    input  logic                in_valid,
    input  logic                out_ready,
    output logic                in_ready,
    output logic                out_valid,
    output logic                row_last,
    output logic                tbl_last
);

    logic keep;

    // Select bit of the current column.
    assign keep = keep_mask[col];

    // Handshake gating and end-of-row / end-of-table marks.
    always_comb begin
        out_valid = busy & in_valid & keep;
        in_ready  = busy & (keep ? out_ready : 1'b1);
        row_last  = out_valid & (col == last_col);
        tbl_last  = row_last & (row == rows_m1);
    end

endmodule

// File: rtl/colproj_stream.sv
// Masked column projection stream, top level.
// Latches a job configuration on start, then forwards or drops each input
// column word by its mask bit without buffering any row.
// Assumes upstream holds a pending word steady until it is taken.
module colproj_stream #(
    parameter int DATA_W   = 32,
    parameter int MAX_COLS = 32,
    parameter int ROW_W    = 16,
    localparam int COL_W   = $clog2(MAX_COLS),
    localparam int CNT_W   = $clog2(MAX_COLS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_COLS-1:0] cfg_mask,
    input  logic [CNT_W-1:0]    cfg_cols,
    input  logic [ROW_W-1:0]    cfg_rows,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_row_last,
    output logic                out_tbl_last,
    output logic [CNT_W-1:0]    out_width,
    output logic                busy,
    output logic                done,
    output logic                err
);

    logic                launch;
    logic                beat;
    logic                bad_cfg;
    logic                no_rows;
    logic [MAX_COLS-1:0] keep_mask;
    logic [COL_W-1:0]    cols_m1;
    logic [ROW_W-1:0]    rows_m1;
    logic [COL_W-1:0]    last_col;
    logic [COL_W-1:0]    col;
    logic [ROW_W-1:0]    row;

    // Start is honoured only between jobs; a beat is an accepted input word.
    assign launch   = start & ~busy;
    assign beat     = in_valid & in_ready;
    assign out_data = in_data;

    colproj_cfg #(
        .MAX_COLS (MAX_COLS),
        .ROW_W    (ROW_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .cfg_mask    (cfg_mask),
        .cfg_cols    (cfg_cols),
        .cfg_rows    (cfg_rows),
        .bad_cfg     (bad_cfg),
        .no_rows     (no_rows),
        .keep_mask_q (keep_mask),
        .cols_m1_q   (cols_m1),
        .rows_m1_q   (rows_m1),
        .width_q     (out_width),
        .last_col_q  (last_col)
    );

    colproj_walker #(
        .MAX_COLS (MAX_COLS),
        .ROW_W    (ROW_W)
    ) i_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .bad_cfg (bad_cfg),
        .no_rows (no_rows),
        .beat    (beat),
        .cols_m1 (cols_m1),
        .rows_m1 (rows_m1),
        .busy    (busy),
        .done    (done),
        .err     (err),
        .col_q   (col),
        .row_q   (row)
    );

    colproj_gate #(
        .MAX_COLS (MAX_COLS),
        .ROW_W    (ROW_W)
    ) i_gate (
        .busy      (busy),
        .keep_mask (keep_mask),
        .col       (col),
        .row       (row),
        .last_col  (last_col),
        .rows_m1   (rows_m1),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .row_last  (out_row_last),
        .tbl_last  (out_tbl_last)
    );

endmodule

// File: rtl/colproj_chk.sv
// Protocol checker for the column projection stream, bound to the top.
// Assumes upstream holds a pending word steady while a job runs.
module colproj_chk #(
    parameter int DATA_W   = 32,
    parameter int MAX_COLS = 32,
    parameter int ROW_W    = 16,
    localparam int CNT_W   = $clog2(MAX_COLS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_row_last,
    input logic              out_tbl_last,
    input logic [CNT_W-1:0]  out_width,
    input logic              busy,
    input logic              done,
    input logic              err
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    // R3
    kept_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && (in_ready == out_ready)));

    // R3 (relies on upstream holding a waiting word)
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && busy) |=> (out_valid && $stable(out_data)));

    // R6
    tbl_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tbl_last |-> (out_row_last && out_valid));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R7
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(out_width));

    // R7
    width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_width <= CNT_W'(MAX_COLS));

endmodule

bind colproj_stream colproj_chk #(
    .DATA_W   (DATA_W),
    .MAX_COLS (MAX_COLS),
    .ROW_W    (ROW_W)
) i_colproj_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_row_last (out_row_last),
    .out_tbl_last (out_tbl_last),
    .out_width    (out_width),
    .busy         (busy),
    .done         (done),
    .err          (err)
);

// File: tb/test_colproj_stream.sv
module test_colproj_stream;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_mask = '0;
    logic [5:0]  cfg_cols = '0;
    logic [15:0] cfg_rows = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_row_last;
    logic        out_tbl_last;
    logic [5:0]  out_width;
    logic        busy;
    logic        done;
    logic        err;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    logic [15:0] lfsr = 16'hACE1;

    // mask[63:32], cols[31:24], rows[23:8], mode[7:0]
    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_000F, 8'd4,  16'd3, 8'd0},
        {32'h0000_00A5, 8'd8,  16'd4, 8'd1},
        {32'hFFFF_FFFF, 8'd32, 16'd2, 8'd0},
        {32'h8000_0001, 8'd32, 16'd2, 8'd2},
        {32'h0000_0001, 8'd1,  16'd5, 8'd3},
        {32'hF0F0_0006, 8'd6,  16'd3, 8'd3},
        {32'h0000_0010, 8'd5,  16'd4, 8'd1},
        {32'h0000_0003, 8'd16, 16'd3, 8'd2}
    };

    always #5 clk = ~clk;

    colproj_stream i_colproj_stream (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_mask     (cfg_mask),
        .cfg_cols     (cfg_cols),
        .cfg_rows     (cfg_rows),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_row_last (out_row_last),
        .out_tbl_last (out_tbl_last),
        .out_width    (out_width),
        .busy         (busy),
        .done         (done),
        .err          (err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int r, input int c);
        return {1'b1, 15'(r), 11'h155, 5'(c)};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_case(input logic [31:0] mask, input int cols, input int rows,
                            input int mode);
        logic [63:0] lowm;
        logic [31:0] emask;
        int last;
        int total;
        int in_idx;
        int out_cnt;
        int cycle;
        bit hold;
        bit kept;
        int c_cur;
        int r_cur;
        lowm  = (64'd1 << cols) - 64'd1;
        emask = mask & lowm[31:0];
        last  = 0;
        for (int i = 0; i < 32; i++) if (emask[i]) last = i;
        total = cols * rows;
        cfg_mask = mask;
        cfg_cols = 6'(cols);
        cfg_rows = 16'(rows);
        start = 1'b1;
        tick();
        start = 1'b0;
        // R1: scramble configuration after launch
        cfg_mask = ~mask;
        cfg_cols = 6'(cols ^ 3);
        cfg_rows = 16'(rows + 7);
        in_idx = 0; out_cnt = 0; cycle = 0; hold = 1'b0;
        while (in_idx < total) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!hold) in_valid = (mode == 2 || mode == 3) ? lfsr[0] : 1'b1;
            c_cur = in_idx % cols;
            r_cur = in_idx / cols;
            in_data = word_of(r_cur, c_cur);
            out_ready = (mode == 1) ? cycle[0] : (mode == 3) ? lfsr[5] : 1'b1;
            start = (cycle == 2); // R1: stray start while busy
            @(negedge clk);
            kept = emask[c_cur];
            chk(busy == 1'b1, "R1 busy during job", 64'(busy), 64'd1);
            chk(out_valid == (in_valid && kept), "R3/R4 out_valid gating",
                64'(out_valid), 64'(in_valid && kept));
            chk(in_ready == (kept ? out_ready : 1'b1), "R3/R4 in_ready",
                64'(in_ready), 64'(kept ? out_ready : 1'b1));
            if (out_valid && out_ready) begin
                out_cnt++;
                chk(out_data == in_data, "R3 data passthrough", 64'(out_data), 64'(in_data));
                chk(out_row_last == (c_cur == last), "R6 row last",
                    64'(out_row_last), 64'(c_cur == last));
                chk(out_tbl_last == (c_cur == last && r_cur == rows - 1), "R6 table last",
                    64'(out_tbl_last), 64'(c_cur == last && r_cur == rows - 1));
            end
            hold = in_valid && !in_ready;
            if (in_valid && in_ready) in_idx++;
            tick();
            cycle++;
        end
        in_valid = 1'b0;
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R2 done after last beat", 64'(done), 64'd1);
        chk(busy == 1'b0, "R2 idle after job", 64'(busy), 64'd0);
        chk(err == 1'b0, "R8 err cleared by good job", 64'(err), 64'd0);
        chk(out_width == 6'($countones(emask)), "R7/R5 out_width", 64'(out_width),
            64'($countones(emask)));
        chk(out_cnt == $countones(emask) * rows, "R2 output word count", 64'(out_cnt),
            64'($countones(emask) * rows));
        tick();
        chk(done == 1'b0, "R2 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic launch_only(input logic [31:0] mask, input int cols, input int rows);
        cfg_mask = mask;
        cfg_cols = 6'(cols);
        cfg_rows = 16'(rows);
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    initial begin
        // R10: reset state
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R10 flags after reset", {busy, done, err}, 0);
        chk(!in_ready && !out_valid, "R10 handshake after reset", {in_ready, out_valid}, 0);
        chk(out_width == 0, "R10 width after reset", 64'(out_width), 0);
        tick();

        // R8: empty mask is refused
        launch_only(32'h0, 8, 2);
        in_valid = 1'b1;
        @(negedge clk);
        chk(err == 1'b1, "R8 err on empty mask", 64'(err), 1);
        chk(done == 1'b1 && busy == 1'b0, "R8 done without busy", {done, busy}, 2'b10);
        chk(!in_ready && !out_valid, "R8 nothing accepted", {in_ready, out_valid}, 0);
        chk(out_width == 0, "R7 width of empty job", 64'(out_width), 0);
        tick();
        in_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b1, "R8 err sticky, done pulse", {done, err}, 2'b01);
        tick();

        // R5: only bits beyond the width set counts as empty
        launch_only(32'hFFFF_FF00, 8, 2);
        @(negedge clk);
        chk(err == 1'b1 && busy == 1'b0, "R5 high bits ignored", {err, busy}, 2'b10);
        tick();

        // R9: zero rows
        launch_only(32'h0000_000F, 4, 0);
        @(negedge clk);
        chk(done && !err && !busy, "R9 zero rows", {done, err, busy}, 3'b100);
        chk(out_width == 4, "R7 width on zero rows", 64'(out_width), 4);
        tick();

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][63:32], int'(VEC[v][31:24]), int'(VEC[v][23:8]),
                     int'(VEC[v][7:0]));
        end

        // R4: dropped word taken while output is stalled
        launch_only(32'h0000_0002, 2, 1);
        in_valid = 1'b1;
        in_data = 32'h1111_0000;
        out_ready = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R4 drop ignores out_ready",
            {in_ready, out_valid}, 2'b10);
        tick();
        in_data = 32'h2222_0001;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid && !in_ready, "R3 kept word waits", {out_valid, in_ready}, 2'b10);
            chk(out_data == 32'h2222_0001, "R3 data while stalled", 64'(out_data),
                64'h2222_0001);
            tick();
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_row_last && out_tbl_last, "R6 single kept column ends table",
            {out_row_last, out_tbl_last}, 2'b11);
        tick();
        in_valid = 1'b0;
        @(negedge clk);
        chk(done && !busy, "R2 done after stalled job", {done, busy}, 2'b10);
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule